// File: doc/BRIEF.md
# Serial Receiver with Halting Error Flags

This block receives asynchronous serial characters on one line. A start bit is detected on a falling edge of the line and confirmed half a bit later. The data bits follow with the least significant bit first, then an optional parity bit, then one or two stop bits. All sampling uses a 16x oversampling tick that arrives from outside. Each completed character is written into a data register. Three flags report the result: a data-ready flag, a framing-error flag and a parity-error flag.

The flags are read and cleared through a small register port. Software clears an error flag by reading the status register while the flag is set and then writing a 0 to that bit. While either error flag is set, the receiver starts no new character. A character that has an error is still stored, but it never raises data-ready. The bench and the rest of the chip can also see the three flags directly as outputs.

Top module: `serial_rx_sticky`

## Requirements
- R1: After reset the ready, framing-error and parity-error flags are 0 and the data register reads 0.
- R2: A falling edge starts a frame only when the line is still 0 at the 8th tick after the edge. Otherwise the edge is a false start, and the receiver returns to idle with no effect on the flags or the data.
- R3: A correct frame sets ready (status bit 0) and writes the character into the data register. Data bits arrive least significant bit first. In 7-bit mode the most significant bit of the data register reads 0.
- R4: A first stop bit sampled as 0 sets the framing-error flag (status bit 1). The character is still stored, but ready is not set.
- R5: In two-stop-bit mode only the first stop bit is checked. A 0 in the second stop bit causes no error.
- R6: With parity enabled, the data bits plus the parity bit must hold an even number of 1s when odd-select is 0, or an odd number when it is 1. A mismatch sets the parity-error flag (status bit 2), stores the character and leaves ready unchanged.
- R7: While either error flag is 1, no frame is received. The data register and all flags keep their values.
- R8: Writing 0 to an error bit of the status register (address 0) clears that flag only after a status read has seen the flag as 1. A write without such a read leaves the flag set. Writing 1 has no effect. Each flag is qualified on its own.
- R9: Reading the data register (address 1) clears ready.
- R10: While receive enable is 0, no frame is received, and a frame already in progress is dropped. The error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idles at 1 |
| rx_en_i | input | 1 | Receive enable |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_seven_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop_i | input | 1 | Two stop bits |
| bus_sel_i | input | 1 | Register address: 0 = status, 1 = data |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe (status register only) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| rdy_o | output | 1 | Data-ready flag |
| ferr_o | output | 1 | Framing-error flag |
| perr_o | output | 1 | Parity-error flag |

## Verification
The assertions check these rules on every cycle:
- the receiver stays idle while an error is pending;
- an error flag that has not been armed cannot drop;
- a frame with an error never raises ready;
- every completed frame loads the data register;
- a data read clears ready.

Some behaviours can only be shown by the bench's scenarios, because they depend on whole frames driven over many ticks:
- correct bit order and 7-bit masking;
- parity polarity;
- the unchecked second stop bit;
- rejection of a false start;
- flags held while enable is low.

// File: rtl/srx_pkg.sv
// Package: shared types and status register bit positions for the serial receiver.
// Assumes: nothing beyond the standard language.
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_t;

    localparam int STAT_RDY  = 0;
    localparam int STAT_FERR = 1;
    localparam int STAT_PERR = 2;
endpackage

// File: rtl/srx_frame.sv
// srx_frame: oversampled frame engine. It finds the start bit, samples each bit
// at its centre, checks parity and the first stop bit, and pulses done_o with
// the character and its error events.
// Assumes: the configuration is static during a frame, and tick_i is one cycle wide.
module srx_frame
    import srx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic          en_i,
    input  logic          hold_i,
    input  logic          seven_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          two_stop_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          ferr_o,
    output logic          perr_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [BW-1:0] nbits;
    logic [DW-1:0] shreg;
    logic          par_bad;
    logic          rx_q;

    // Number of data bits for the current mode.
    assign nbits  = seven_i ? BW'(DW - 1) : BW'(DW);
    // Character aligned to bit 0; in short mode the top bit is 0.
    assign data_o = seven_i ? {1'b0, shreg[DW-1:1]} : shreg;

    // Frame state machine, advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bad <= 1'b0;
            rx_q    <= 1'b1;
            done_o  <= 1'b0;
            ferr_o  <= 1'b0;
            perr_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) rx_q <= rx_i;
            if (!en_i) begin
                state <= ST_IDLE;
            end else if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!hold_i && rx_q && !rx_i) begin
                            state   <= ST_START;
                            cnt     <= '0;
                            par_bad <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt  <= '0;
                            bitn <= '0;
                            state <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rx_i, shreg[DW-1:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == nbits - 1'b1)
                                state <= par_en_i ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bad <= (^data_o) ^ rx_i ^ par_odd_i;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            done_o <= 1'b1;
                            ferr_o <= !rx_i;
                            perr_o <= par_en_i && par_bad;
                            state  <= two_stop_i ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (cnt == LAST) state <= ST_IDLE;
                        else             cnt   <= cnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_HOLD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && state == ST_IDLE) |=> (state == ST_IDLE)); // R7
    AST_DONE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> !done_o); // R10
endmodule

// File: rtl/srx_status.sv
// srx_status: data register, the three flags and the register port.
// An error flag is cleared only by a write of 0 after a status read has seen it set.
// Assumes: one bus access per cycle, and done_i is a single-cycle pulse.
module srx_status
    import srx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [DW-1:0] data_i,
    input  logic          fe_i,
    input  logic          pe_i,
    input  logic          sel_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rdy_o,
    output logic          ferr_o,
    output logic          perr_o
);
    logic [DW-1:0] data_q;
    logic          arm_f;
    logic          arm_p;
    logic [DW-1:0] stat_w;

    // Status word assembled from the flags.
    always_comb begin
        stat_w            = '0;
        stat_w[STAT_RDY]  = rdy_o;
        stat_w[STAT_FERR] = ferr_o;
        stat_w[STAT_PERR] = perr_o;
    end

    // Read multiplexer.
    assign rdata_o = sel_i ? data_q : stat_w;

    // Flag, arming and data register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_o  <= 1'b0;
            ferr_o <= 1'b0;
            perr_o <= 1'b0;
            arm_f  <= 1'b0;
            arm_p  <= 1'b0;
        end else begin
            if (rd_i && !sel_i) begin
                if (ferr_o) arm_f <= 1'b1;
                if (perr_o) arm_p <= 1'b1;
            end
            if (wr_i && !sel_i) begin
                if (!wdata_i[STAT_FERR] && arm_f && ferr_o) begin
                    ferr_o <= 1'b0;
                    arm_f  <= 1'b0;
                end
                if (!wdata_i[STAT_PERR] && arm_p && perr_o) begin
                    perr_o <= 1'b0;
                    arm_p  <= 1'b0;
                end
            end
            if (rd_i && sel_i) rdy_o <= 1'b0;
            if (done_i) begin
                data_q <= data_i;
                if (fe_i) ferr_o <= 1'b1;
                if (pe_i) perr_o <= 1'b1;
                if (!fe_i && !pe_i) rdy_o <= 1'b1;
            end
        end
    end

    AST_FERR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_o && !arm_f) |=> ferr_o); // R8
    AST_PERR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_o && !arm_p) |=> perr_o); // R8
    AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (fe_i || pe_i) && !rdy_o) |=> !rdy_o); // R4
    AST_FRAME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (data_q == $past(data_i))); // R3
    AST_READ_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i && !done_i) |=> !rdy_o); // R9
endmodule

// File: rtl/serial_rx_sticky.sv
// serial_rx_sticky: top of the serial receiver. It joins the frame engine and
// the status registers, and uses the error flags to hold the receiver idle.
// Assumes: tick_i runs at 16x the bit rate and the configuration is static per frame.
module serial_rx_sticky
    import srx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          rx_en_i,
    input  logic          tick_i,
    input  logic          cfg_seven_i,
    input  logic          cfg_par_en_i,
    input  logic          cfg_par_odd_i,
    input  logic          cfg_two_stop_i,
    input  logic          bus_sel_i,
    input  logic          bus_rd_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          rdy_o,
    output logic          ferr_o,
    output logic          perr_o
);
    logic          done;
    logic [DW-1:0] fdata;
    logic          fe_ev;
    logic          pe_ev;
    logic          hold;

    // A pending error blocks new frames.
    assign hold = ferr_o || perr_o;

    srx_frame #(.DW(DW), .OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .rx_i       (rx_i),
        .en_i       (rx_en_i),
        .hold_i     (hold),
        .seven_i    (cfg_seven_i),
        .par_en_i   (cfg_par_en_i),
        .par_odd_i  (cfg_par_odd_i),
        .two_stop_i (cfg_two_stop_i),
        .done_o     (done),
        .data_o     (fdata),
        .ferr_o     (fe_ev),
        .perr_o     (pe_ev)
    );

    srx_status #(.DW(DW)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .data_i  (fdata),
        .fe_i    (fe_ev),
        .pe_i    (pe_ev),
        .sel_i   (bus_sel_i),
        .rd_i    (bus_rd_i),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .rdy_o   (rdy_o),
        .ferr_o  (ferr_o),
        .perr_o  (perr_o)
    );

    AST_NO_FRAME_WHILE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !bus_wr_i) |=> !done); // R7
endmodule

// File: tb/serial_rx_sticky_bench.sv
module serial_rx_sticky_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       rx_en = 1'b1;
    logic       tick = 1'b0;
    logic       seven = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'hFF;
    logic [7:0] rdata;
    logic       rdy, ferr, perr;

    int n_checks = 0;
    int n_fail = 0;
    int tdiv = 0;

    // Expected model state.
    logic [7:0] m_data = 8'h00;
    logic       m_rdy = 1'b0, m_fe = 1'b0, m_pe = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       rdy;
        logic       fe;
        logic       pe;
        string      tag;
    } exp_t;
    exp_t sb[$];
    event chk_ev, chk_done;

    serial_rx_sticky u_serial_rx_sticky (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .rx_en_i(rx_en), .tick_i(tick),
        .cfg_seven_i(seven), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
        .cfg_two_stop_i(two_stop), .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rdy_o(rdy), .ferr_o(ferr),
        .perr_o(perr)
    );

    always #10 clk = ~clk;

    // Tick every 4 clocks.
    always @(posedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 3);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (tick) c++;
        end
    endtask

    task automatic line(input logic b, input int n);
        rx = b;
        wait_ticks(n);
    endtask

    // Driver: sends one frame, updates the model and pushes the expectation.
    task automatic send(input logic [7:0] d, input bit s7, input bit pen, input bit podd,
                        input bit two, input bit bad_stop, input bit bad_par,
                        input bit bad_stop2, input string tag);
        int nb = s7 ? 7 : 8;
        logic [7:0] dm = s7 ? {1'b0, d[6:0]} : d;
        logic p;
        exp_t e;
        seven = s7; par_en = pen; par_odd = podd; two_stop = two;
        p = (^dm) ^ podd ^ bad_par;
        line(1'b1, 32);
        line(1'b0, 16);
        for (int i = 0; i < nb; i++) line(dm[i], 16);
        if (pen) line(p, 16);
        line(!bad_stop, 16);
        if (two) line(!bad_stop2, 16);
        line(1'b1, 32);
        if (rx_en && !m_fe && !m_pe) begin
            m_data = dm;
            if (bad_stop) m_fe = 1'b1;
            if (pen && bad_par) m_pe = 1'b1;
            if (!bad_stop && !(pen && bad_par)) m_rdy = 1'b1;
        end
        e.data = m_data; e.rdy = m_rdy; e.fe = m_fe; e.pe = m_pe; e.tag = tag;
        sb.push_back(e);
        ->chk_ev;
        @(chk_done);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.data = m_data; e.rdy = m_rdy; e.fe = m_fe; e.pe = m_pe; e.tag = tag;
        sb.push_back(e);
        ->chk_ev;
        @(chk_done);
    endtask

    // Monitor: pops the expectation and compares flags and the data register.
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            e = sb.pop_front();
            @(negedge clk);
            sel = 1'b1;
            #1;
            check(rdata == e.data, {e.tag, " data"}, rdata, e.data);
            sel = 1'b0;
            #1;
            check(rdy == e.rdy, {e.tag, " rdy"}, rdy, e.rdy);
            check(ferr == e.fe, {e.tag, " ferr"}, ferr, e.fe);
            check(perr == e.pe, {e.tag, " perr"}, perr, e.pe);
            check(rdata == {5'b0, e.pe, e.fe, e.rdy}, {e.tag, " status"}, rdata,
                  {5'b0, e.pe, e.fe, e.rdy});
            ->chk_done;
        end
    end

    task automatic bus_read(input logic s);
        @(negedge clk);
        sel = s; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; sel = 1'b0;
        if (s) m_rdy = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] v);
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0; wdata = 8'hFF;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset");

        send(8'hA5, 0, 0, 0, 0, 0, 0, 0, "R3 good 8N1");
        bus_read(1'b1);
        expect_now("R9 data read clears ready");

        send(8'hDA, 1, 1, 0, 0, 0, 0, 0, "R3 R6 7-bit even good");
        send(8'h3C, 0, 1, 1, 0, 0, 0, 0, "R6 8-bit odd good");
        bus_read(1'b1);

        // False start: low for 4 ticks only.
        line(1'b0, 4);
        line(1'b1, 40);
        expect_now("R2 false start ignored");
        send(8'h81, 0, 0, 0, 0, 0, 0, 0, "R2 frame after false start");
        bus_read(1'b1);

        send(8'h5E, 0, 0, 0, 0, 1, 0, 0, "R4 bad stop");
        send(8'h11, 0, 0, 0, 0, 0, 0, 0, "R7 blocked by ferr");
        bus_write(8'h00);
        expect_now("R8 write without read keeps ferr");

        rx_en = 1'b0;
        repeat (20) @(negedge clk);
        expect_now("R10 enable low keeps ferr");
        rx_en = 1'b1;

        bus_read(1'b0);
        bus_write(8'hFF);
        expect_now("R8 writing ones has no effect");
        bus_write(8'h00);
        m_fe = 1'b0;
        expect_now("R8 armed clear");

        send(8'h47, 0, 1, 0, 0, 0, 1, 0, "R6 even parity error");
        send(8'h22, 0, 0, 0, 0, 0, 0, 0, "R7 blocked by perr");
        bus_read(1'b0);
        bus_write(8'h00);
        m_pe = 1'b0;
        expect_now("R8 perr armed clear");

        send(8'h6B, 1, 1, 1, 0, 0, 1, 0, "R6 7-bit odd parity error");
        bus_read(1'b0);
        bus_write(8'h00);
        m_pe = 1'b0;

        send(8'hC3, 0, 0, 0, 1, 0, 0, 1, "R5 bad second stop ignored");
        bus_read(1'b1);

        rx_en = 1'b0;
        send(8'h99, 0, 0, 0, 0, 0, 0, 0, "R10 disabled frame ignored");
        rx_en = 1'b1;

        send(8'hF0, 0, 1, 1, 1, 1, 1, 0, "R4 R6 both errors");
        bus_read(1'b0);
        bus_write(8'hFD);
        m_fe = 1'b0;
        expect_now("R8 per-flag clear");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule